// File: doc/BRIEF.md
# Pipeline Exception Controller

This block handles exceptions for a five-stage in-order pipeline. Two hazard sources feed it. The decode stage reports an undefined opcode, and the execute stage reports an arithmetic overflow. Each source comes with the program counter of the instruction that raised it. In the cycle an exception is taken, the block does four things:

- It picks the older of the faulting instructions.
- It raises flush strobes for the stages that hold the faulting instruction and every younger one.
- It blocks the register write of an overflowing instruction.
- It sends the fetch unit to the handler entry point.

On the following clock edge it latches the saved return address and the cause code. The return address is the faulting PC plus 4, and handler software corrects it.

A static mode pin chooses between two kinds of handler entry. In single-entry mode there is one common entry point. In vectored mode the entry depends on the cause, with one 32-byte slot per cause above a base address. The fault flags are plain per-cycle qualifiers and have no ready or acknowledge. The pipeline cannot hold a fault back, so the block takes a flagged fault in the same cycle it appears. The one exception is the cycle right after a take, when any flag is treated as stale.

Top module: `exc_ctl_top`

## Requirements
- R1: While reset is applied and after it is released, the saved return address and the cause code read 0, and no flush or redirect is driven while no fault flag is high.
- R2: A decode-stage undefined opcode that is taken alone produces cause code 0 and a saved return address equal to the decode PC plus 4. Both values are visible from the clock edge that ends the take cycle.
- R3: An execute-stage overflow that is taken produces cause code 1 and a saved return address equal to the execute PC plus 4. Both values are visible from the clock edge that ends the take cycle.
- R4: When both faults are flagged in the same cycle, the overflow is taken, because the execute-stage instruction is older. The decode fault leaves no trace in the cause code or the saved address.
- R5: When an undefined opcode is taken, the fetch and decode flush strobes are high in that cycle. The execute flush and the write-kill are low, so the older execute-stage instruction still completes.
- R6: When an overflow is taken, the fetch, decode and execute flush strobes and the write-kill are all high in that cycle.
- R7: With the mode pin low, the redirect address during a take is 0x80000180.
- R8: With the mode pin high, the redirect address during a take is 0xC0000000 + 0x20 × cause: 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow.
- R9: The redirect valid strobe is high only in the take cycle, never for two cycles in a row. Fault flags in the cycle right after a take are ignored: no flush, no redirect, and no change to the saved address or the cause code.
- R10: The saved return address and the cause code keep their values in every cycle in which no exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_mode_i | input | 1 | 1 selects cause-vectored handler entry, 0 selects the single entry point |
| dec_undef_i | input | 1 | Decode stage holds an undefined opcode |
| dec_pc_i | input | 32 | PC of the decode-stage instruction |
| exe_ovf_i | input | 1 | Execute stage detected an arithmetic overflow |
| exe_pc_i | input | 32 | PC of the execute-stage instruction |
| flush_fetch_o | output | 1 | Discard the instruction in fetch |
| flush_decode_o | output | 1 | Discard the instruction in decode |
| flush_execute_o | output | 1 | Discard the instruction in execute |
| exe_wr_kill_o | output | 1 | Block the register write of the execute-stage instruction |
| redir_valid_o | output | 1 | Fetch must continue at redir_pc_o on the next cycle |
| redir_pc_o | output | 32 | Handler entry address, meaningful while redir_valid_o is high |
| epc_o | output | 32 | Saved return address (faulting PC + 4) |
| cause_o | output | 1 | Saved cause: 0 undefined opcode, 1 overflow |

## Verification
The assertions check these rules on every cycle:
- the one-cycle redirect pulse
- the flush pattern and write-kill for each fault source
- the latching of cause code and return address from the chosen source
- the holding of both registers between takes
- the single-entry address

The bench's scenarios are needed for the rest. Only they show that simultaneous faults resolve toward the execute stage, that a flag arriving right after a take is discarded, and that the vectored addresses differ by cause. Random flag and PC sequences, checked cycle by cycle against a reference model, cover the mix of these cases.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

  typedef enum logic [0:0] {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } exc_cause_e;

  typedef struct packed {
    logic       hit;
    logic       from_exe;
    exc_cause_e cause;
  } exc_sel_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_ctl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            dec_undef,
  input  logic [XLEN-1:0] dec_pc,
  input  logic            exe_ovf,
  input  logic [XLEN-1:0] exe_pc,
  input  logic            blocked,
  output exc_sel_t        sel,
  output logic [XLEN-1:0] fault_pc
);

  // The execute stage holds the older instruction, so it wins.
  always_comb begin
    sel      = '0;
    fault_pc = '0;
    if (!blocked) begin
      if (exe_ovf) begin
        sel.hit      = 1'b1;
        sel.from_exe = 1'b1;
        sel.cause    = CAUSE_OVF;
        fault_pc     = exe_pc;
      end else if (dec_undef) begin
        sel.hit      = 1'b1;
        sel.from_exe = 1'b0;
        sel.cause    = CAUSE_UNDEF;
        fault_pc     = dec_pc;
      end
    end
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int              XLEN       = 32,
  parameter int              CAUSE_W    = 1,
  parameter bit              VEC_EN     = 1'b1,
  parameter logic [XLEN-1:0] FIXED_PC   = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter int              SLOT_LG2   = 5
) (
  input  logic               vec_mode,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    handler_pc
);

  localparam int PAD_W = XLEN - CAUSE_W;

  generate
    if (VEC_EN) begin : g_vec
      logic [XLEN-1:0] slot_off;
      assign slot_off   = {{PAD_W{1'b0}}, cause} << SLOT_LG2;
      assign handler_pc = vec_mode ? (VEC_BASE + slot_off) : FIXED_PC;
    end else begin : g_fixed
      logic unused_in;
      assign unused_in  = vec_mode ^ (^cause);
      assign handler_pc = FIXED_PC;
    end
  endgenerate

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 1,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [XLEN-1:0]    fault_pc,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               blk_q
);

  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      blk_q   <= 1'b0;
    end else begin
      blk_q <= take;
      if (take) begin
        epc_q   <= fault_pc + STEP;
        cause_q <= cause_in;
      end
    end
  end

endmodule

// File: rtl/exc_ctl_top.sv
module exc_ctl_top
  import exc_ctl_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CAUSE_W  = 1,
  parameter bit              VEC_EN   = 1'b1,
  parameter logic [XLEN-1:0] FIXED_PC = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE = 32'hC000_0000,
  parameter int              SLOT_LG2 = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vec_mode_i,
  input  logic               dec_undef_i,
  input  logic [XLEN-1:0]    dec_pc_i,
  input  logic               exe_ovf_i,
  input  logic [XLEN-1:0]    exe_pc_i,
  output logic               flush_fetch_o,
  output logic               flush_decode_o,
  output logic               flush_execute_o,
  output logic               exe_wr_kill_o,
  output logic               redir_valid_o,
  output logic [XLEN-1:0]    redir_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);

  exc_sel_t           sel;
  logic [XLEN-1:0]    fault_pc;
  logic               blk_q;
  logic [CAUSE_W-1:0] sel_cause;

  assign sel_cause = CAUSE_W'(sel.cause);

  exc_arbiter #(.XLEN(XLEN)) arb_i (
    .dec_undef (dec_undef_i),
    .dec_pc    (dec_pc_i),
    .exe_ovf   (exe_ovf_i),
    .exe_pc    (exe_pc_i),
    .blocked   (blk_q),
    .sel       (sel),
    .fault_pc  (fault_pc)
  );

  exc_vector_gen #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_EN(VEC_EN),
    .FIXED_PC(FIXED_PC), .VEC_BASE(VEC_BASE), .SLOT_LG2(SLOT_LG2)
  ) vec_i (
    .vec_mode   (vec_mode_i),
    .cause      (sel_cause),
    .handler_pc (redir_pc_o)
  );

  exc_state_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (sel.hit),
    .cause_in (sel_cause),
    .fault_pc (fault_pc),
    .epc_q    (epc_o),
    .cause_q  (cause_o),
    .blk_q    (blk_q)
  );

  assign flush_fetch_o   = sel.hit;
  assign flush_decode_o  = sel.hit;
  assign flush_execute_o = sel.hit & sel.from_exe;
  assign exe_wr_kill_o   = sel.hit & sel.from_exe;
  assign redir_valid_o   = sel.hit;

endmodule

// File: rtl/exc_ctl_chk.sv
module exc_ctl_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vec_mode_i,
  input logic               dec_undef_i,
  input logic [XLEN-1:0]    dec_pc_i,
  input logic               exe_ovf_i,
  input logic [XLEN-1:0]    exe_pc_i,
  input logic               flush_fetch_o,
  input logic               flush_decode_o,
  input logic               flush_execute_o,
  input logic               exe_wr_kill_o,
  input logic               redir_valid_o,
  input logic [XLEN-1:0]    redir_pc_o,
  input logic [XLEN-1:0]    epc_o,
  input logic [CAUSE_W-1:0] cause_o
);

  // R9
  redir_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |=> !redir_valid_o);

  // R2
  undef_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && !exe_ovf_i) |=>
      (cause_o == '0) && (epc_o == $past(dec_pc_i) + XLEN'(4)));

  // R3
  ovf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && exe_ovf_i) |=>
      (cause_o == CAUSE_W'(1)) && (epc_o == $past(exe_pc_i) + XLEN'(4)));

  // R5
  undef_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && !exe_ovf_i) |->
      (flush_fetch_o && flush_decode_o && !flush_execute_o && !exe_wr_kill_o));

  // R6
  ovf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && exe_ovf_i) |->
      (flush_fetch_o && flush_decode_o && flush_execute_o && exe_wr_kill_o));

  // R7
  fixed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && !vec_mode_i) |-> (redir_pc_o == 32'h8000_0180));

  // R10
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid_o |=> ($stable(epc_o) && $stable(cause_o)));

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_undef_i && !exe_ovf_i) |-> (!flush_fetch_o && !redir_valid_o));

endmodule

bind exc_ctl_top exc_ctl_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i),
  .dec_undef_i(dec_undef_i), .dec_pc_i(dec_pc_i),
  .exe_ovf_i(exe_ovf_i), .exe_pc_i(exe_pc_i),
  .flush_fetch_o(flush_fetch_o), .flush_decode_o(flush_decode_o),
  .flush_execute_o(flush_execute_o), .exe_wr_kill_o(exe_wr_kill_o),
  .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
  .epc_o(epc_o), .cause_o(cause_o)
);

// File: tb/exc_ctl_top_tb.sv
module exc_ctl_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_mode_i = 1'b0;
  logic        dec_undef_i = 1'b0;
  logic [31:0] dec_pc_i = '0;
  logic        exe_ovf_i = 1'b0;
  logic [31:0] exe_pc_i = '0;
  logic        flush_fetch_o, flush_decode_o, flush_execute_o, exe_wr_kill_o;
  logic        redir_valid_o;
  logic [31:0] redir_pc_o, epc_o;
  logic [0:0]  cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        m_blk = 1'b0;
  logic [31:0] m_epc = '0;
  logic        m_cause = 1'b0;

  always #2 clk = ~clk;

  exc_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i),
    .dec_undef_i(dec_undef_i), .dec_pc_i(dec_pc_i),
    .exe_ovf_i(exe_ovf_i), .exe_pc_i(exe_pc_i),
    .flush_fetch_o(flush_fetch_o), .flush_decode_o(flush_decode_o),
    .flush_execute_o(flush_execute_o), .exe_wr_kill_o(exe_wr_kill_o),
    .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
    .epc_o(epc_o), .cause_o(cause_o)
  );

  function automatic logic [31:0] entry_addr(input logic vm, input logic c);
    if (!vm) return 32'h8000_0180;
    return c ? 32'hC000_0020 : 32'hC000_0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: check registered state, drive, check combinational, advance model.
  task automatic step(input logic vm, input logic u, input logic [31:0] dpc,
                      input logic o, input logic [31:0] xpc, input string tag);
    logic take;
    @(negedge clk);
    chk({tag, " R10 epc"}, epc_o, m_epc);
    chk({tag, " R10 cause"}, {31'd0, cause_o}, {31'd0, m_cause});
    vec_mode_i = vm; dec_undef_i = u; dec_pc_i = dpc; exe_ovf_i = o; exe_pc_i = xpc;
    #1;
    take = (u | o) & ~m_blk;
    chk({tag, " R9 redirect"}, {31'd0, redir_valid_o}, {31'd0, take});
    chk({tag, " R5 flush_fetch"}, {31'd0, flush_fetch_o}, {31'd0, take});
    chk({tag, " R5 flush_decode"}, {31'd0, flush_decode_o}, {31'd0, take});
    chk({tag, " R6 flush_execute"}, {31'd0, flush_execute_o}, {31'd0, take & o});
    chk({tag, " R6 wr_kill"}, {31'd0, exe_wr_kill_o}, {31'd0, take & o});
    if (take) begin
      chk({tag, vm ? " R8 vector" : " R7 entry"}, redir_pc_o, entry_addr(vm, o));
      m_epc   = (o ? xpc : dpc) + 32'd4;
      m_cause = o;
    end
    m_blk = take;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 epc in reset", epc_o, 32'd0);
    chk("R1 cause in reset", {31'd0, cause_o}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "R1 idle");
    // R2 undef alone, fixed entry (R7)
    step(1'b0, 1'b1, 32'h0000_1000, 1'b0, 32'h0000_0ffc, "R2 undef");
    step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "R2 after");
    chk("R2 epc", epc_o, 32'h0000_1004);
    // R3 overflow alone, vectored (R8)
    step(1'b1, 1'b0, 32'h0, 1'b1, 32'h0000_2040, "R3 ovf");
    step(1'b1, 1'b0, 32'h0, 1'b0, 32'h0, "R3 after");
    chk("R3 cause", {31'd0, cause_o}, 32'd1);
    // R8 vectored undef
    step(1'b1, 1'b1, 32'h0000_3000, 1'b0, 32'h0, "R8 undef vec");
    step(1'b1, 1'b0, 32'h0, 1'b0, 32'h0, "R8 after");
    // R4 both in the same cycle
    step(1'b0, 1'b1, 32'h0000_4004, 1'b1, 32'h0000_4000, "R4 both");
    step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "R4 after");
    chk("R4 epc from exe", epc_o, 32'h0000_4004);
    // R9 back-to-back flags: second is ignored
    step(1'b0, 1'b1, 32'h0000_5000, 1'b0, 32'h0, "R9 first");
    step(1'b0, 1'b0, 32'h0, 1'b1, 32'h0000_6000, "R9 stale");
    step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "R9 after");
    chk("R9 epc unchanged", epc_o, 32'h0000_5004);
    // random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[0], r[3:1] == 3'd0, {$urandom() & 32'hffff_fffc},
           r[6:4] == 3'd0, {$urandom() & 32'hffff_fffc}, "RND");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule